// File: doc/BRIEF.md
# GF(2^233) Single-Cycle Field Multiplier

This block multiplies two elements of the binary field GF(2^233) held in polynomial basis and returns their product reduced by the trinomial x^233 + x^74 + 1. Bit i of each operand and of the result is the coefficient of x^i. The raw carry-less product is formed by a recursive Karatsuba tree. Each node cuts its operands into a low half and a zero-padded high half of equal width, so the widths go 233, 117, 59, 30 and then 15. At 15 bits or fewer a node falls back to a schoolbook carry-less leaf. The resulting 465-bit polynomial is folded twice onto the field width.

A caller places the two operands on the inputs and raises the start strobe for one cycle. On the next clock edge the reduced product is captured in the output register and the done strobe rises for that one cycle. A start strobe may be raised on every cycle. The result register holds its value until the next start. Squaring needs no separate path: the caller applies the same element to both operands.

Top module: `gf233_kmul`

## Requirements
- R1: With bit i of each operand taken as the coefficient of x^i, the output after a start edge equals opa·opb reduced modulo x^233 + x^74 + 1. It is captured on the clock edge that samples `go` high.
- R2: `prod_vld` is 1 in exactly those cycles that follow a cycle with `go` = 1, and is 0 otherwise.
- R3: While `go` is 0, `prod` keeps its value whatever the operands do.
- R4: While `rst_n` is 0, which acts asynchronously, `prod` is all zeros and `prod_vld` is 0.
- R5: Applying the same element to both operands yields its square in the field.
- R6: A zero operand gives a zero result. An operand equal to 1 (only bit 0 set) gives the other operand unchanged.
- R7: Product terms of degree 233 and above are folded away, including terms that need a second fold. x^232·x gives x^74 + 1, and x^232·x^232 gives x^231 + x^146 + x^72.
- R8: Swapping the two operands does not change the result.
- R9: Start strobes on consecutive cycles each produce their own product, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe; operands sampled on this edge |
| opa | input | 233 | First operand, bit i = coefficient of x^i |
| opb | input | 233 | Second operand, same layout |
| prod | output | 233 | Registered reduced product |
| prod_vld | output | 1 | High for the cycle in which a new product is presented |

## Verification
Two things can happen in the same cycle: the output register presents one product, and a new start strobe samples the next operands for capture on the coming edge. The bench provokes this with back-to-back start strobes that carry different operand pairs. On every cycle it checks that the presented value is the product of the pair from the cycle before, with the done strobe still high. Each expected value comes from a bit-serial shift-and-reduce model, or from a spread-and-fold model for squares. Both models differ from the Karatsuba-plus-fold structure in the design.

// File: rtl/gf233_pkg.sv
package gf233_pkg;
  // field degree and middle exponent of the reduction trinomial
  localparam int FIELD_W  = 233;
  localparam int TAP_POS  = 74;
  // widest operand still handled by a schoolbook leaf
  localparam int LEAF_MAX = 15;

  typedef logic [FIELD_W-1:0]   felem_t;
  typedef logic [2*FIELD_W-2:0] fwide_t;
endpackage

// File: rtl/gf233_clmul_leaf.sv
// Schoolbook carry-less multiplier used at the bottom of the tree.
module gf233_clmul_leaf #(
  parameter int W = 15
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);
  localparam int PW = 2*W - 1;

  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) begin
      p = p ^ ((PW'(a) & {PW{b[i]}}) << i);
    end
  end
endmodule

// File: rtl/gf233_kara.sv
// Recursive Karatsuba node: splits into equal halves (high half padded),
// three sub-products, recombined with XOR only.
module gf233_kara #(
  parameter int W      = 233,
  parameter int LEAF_W = 15
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);
  localparam int H  = (W + 1) / 2;   // half width (low half)
  localparam int PW = 2*W - 1;       // product width of this node

  generate
    if (W <= LEAF_W) begin : g_leaf
      gf233_clmul_leaf #(.W(W)) u_leaf (
        .a (a),
        .b (b),
        .p (p)
      );
    end else begin : g_split
      logic [H-1:0]   a_lo, a_hi, b_lo, b_hi, a_sum, b_sum;
      logic [2*H-2:0] p_lo, p_hi, p_mid;

      assign a_lo  = a[H-1:0];
      assign b_lo  = b[H-1:0];
      assign a_hi  = H'(a[W-1:H]);
      assign b_hi  = H'(b[W-1:H]);
      assign a_sum = a_lo ^ a_hi;
      assign b_sum = b_lo ^ b_hi;

      gf233_kara #(.W(H), .LEAF_W(LEAF_W)) u_lo (
        .a (a_lo),
        .b (b_lo),
        .p (p_lo)
      );
      gf233_kara #(.W(H), .LEAF_W(LEAF_W)) u_hi (
        .a (a_hi),
        .b (b_hi),
        .p (p_hi)
      );
      gf233_kara #(.W(H), .LEAF_W(LEAF_W)) u_mid (
        .a (a_sum),
        .b (b_sum),
        .p (p_mid)
      );

      // bits dropped by the casts are zero in the exact product
      always_comb begin
        p = (PW'(p_hi) << (2*H))
          ^ PW'(p_lo)
          ^ (PW'(p_mid ^ p_hi ^ p_lo) << H);
      end
    end
  endgenerate
endmodule

// File: rtl/gf233_fold.sv
// Trinomial reduction: each bit at degree i >= M lands on i-M and i-M+TAP.
// Two passes suffice while 2*TAP-2 < M.
module gf233_fold #(
  parameter int M   = 233,
  parameter int TAP = 74
) (
  input  logic [2*M-2:0] c,
  output logic [M-1:0]   r
);
  localparam int S1W = M + TAP - 1;  // width after the first pass
  localparam int H1W = M - 1;        // bits above the field, first pass
  localparam int H2W = TAP - 1;      // bits above the field, second pass

  logic [H1W-1:0] over1;
  logic [S1W-1:0] pass1;
  logic [H2W-1:0] over2;

  always_comb begin
    over1 = c[2*M-2:M];
    pass1 = S1W'(c[M-1:0]) ^ S1W'(over1) ^ (S1W'(over1) << TAP);
    over2 = pass1[S1W-1:M];
    r     = pass1[M-1:0] ^ M'(over2) ^ (M'(over2) << TAP);
  end
endmodule

// File: rtl/gf233_kmul.sv
module gf233_kmul
  import gf233_pkg::*;
#(
  parameter int M    = FIELD_W,
  parameter int TAP  = TAP_POS,
  parameter int LEAF = LEAF_MAX
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [M-1:0] opa,
  input  logic [M-1:0] opb,
  output logic [M-1:0] prod,
  output logic         prod_vld
);
  logic [2*M-2:0] raw_prod;
  logic [M-1:0]   red_prod;
  logic [M-1:0]   prod_d;
  logic           vld_d;

  gf233_kara #(.W(M), .LEAF_W(LEAF)) u_tree (
    .a (opa),
    .b (opb),
    .p (raw_prod)
  );

  gf233_fold #(.M(M), .TAP(TAP)) u_fold (
    .c (raw_prod),
    .r (red_prod)
  );

  // next-state
  always_comb begin
    prod_d = prod;
    if (go) begin
      prod_d = red_prod;
    end
    vld_d = go;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod     <= '0;
      prod_vld <= 1'b0;
    end else begin
      prod     <= prod_d;
      prod_vld <= vld_d;
    end
  end
endmodule

// File: rtl/gf233_kmul_chk.sv
module gf233_kmul_chk #(
  parameter int M = 233
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go,
  input logic [M-1:0] opa,
  input logic [M-1:0] opb,
  input logic [M-1:0] prod,
  input logic         prod_vld
);
  assert_vld_after_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> prod_vld);

  assert_no_vld_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !prod_vld);

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(prod));

  assert_zero_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && opa == '0) |=> (prod == '0));

  assert_unit_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && opa == M'(1)) |=> (prod == $past(opb)));

  assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && opb == M'(1)) |=> (prod == $past(opa)));

  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && prod_vld) |=> prod_vld);
endmodule

bind gf233_kmul gf233_kmul_chk #(.M(M)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .go       (go),
  .opa      (opa),
  .opb      (opb),
  .prod     (prod),
  .prod_vld (prod_vld)
);

// File: tb/tb_gf233_kmul.sv
`timescale 1ns/1ps
module tb_gf233_kmul;
  localparam int M  = 233;
  localparam int NV = 6;

  logic         clk;
  logic         rst_n;
  logic         go;
  logic [M-1:0] opa, opb;
  logic [M-1:0] prod;
  logic         prod_vld;

  int total = 0;
  int bad   = 0;

  localparam logic [M-1:0] VA [NV] = '{
    M'({8{32'h9E3779B9}}),
    {M{1'b1}},
    M'({8{32'h55555555}}),
    M'({8{32'h12345678}}),
    M'({8{32'hC0FFEE11}}),
    {1'b1, {(M-1){1'b0}}}
  };
  localparam logic [M-1:0] VB [NV] = '{
    M'({8{32'h7F4A7C15}}),
    {M{1'b1}},
    M'({8{32'hAAAAAAAA}}),
    M'({8{32'h0F0F0F0F}}),
    M'({8{32'h3C3C0001}}),
    {1'b1, {(M-1){1'b0}}}
  };

  gf233_kmul dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .opa      (opa),
    .opb      (opb),
    .prod     (prod),
    .prod_vld (prod_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // bit-serial shift-and-reduce model
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M-1:0] r;
    logic [M-1:0] low;
    logic         top;
    low = M'(1) | (M'(1) << 74);
    r = '0;
    for (int i = M-1; i >= 0; i--) begin
      top = r[M-1];
      r = r << 1;
      if (top) r = r ^ low;
      if (y[i]) r = r ^ x;
    end
    return r;
  endfunction

  // spread bits then fold one degree at a time
  function automatic logic [M-1:0] ref_sq(input logic [M-1:0] x);
    logic [2*M-2:0] w;
    w = '0;
    for (int i = 0; i < M; i++) w[2*i] = x[i];
    for (int i = 2*M-2; i >= M; i--) begin
      if (w[i]) begin
        w[i] = 1'b0;
        w[i-M] = w[i-M] ^ 1'b1;
        w[i-M+74] = w[i-M+74] ^ 1'b1;
      end
    end
    return w[M-1:0];
  endfunction

  task automatic chk(input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one start strobe; returns at the following falling edge
  task automatic run(input logic [M-1:0] a, input logic [M-1:0] b);
    @(negedge clk);
    opa = a; opb = b; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [M-1:0] held;
    rst_n = 1'b0; go = 1'b0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    chk("R4 reset prod", prod, '0);
    chk("R4 reset vld", M'(prod_vld), M'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // vector table, R1/R2
    for (int k = 0; k < NV; k++) begin
      run(VA[k], VB[k]);
      chk($sformatf("R1 vec%0d", k), prod, ref_mul(VA[k], VB[k]));
      chk($sformatf("R2 vld vec%0d", k), M'(prod_vld), M'(1));
      @(negedge clk);
      chk($sformatf("R2 vld drop vec%0d", k), M'(prod_vld), M'(0));
    end

    // R3: operands change while go is low
    run(VA[0], VB[0]);
    held = prod;
    opa = VA[2]; opb = VB[3];
    repeat (2) @(negedge clk);
    chk("R3 hold", prod, held);
    chk("R3 vld low", M'(prod_vld), M'(0));

    // R5 squaring
    run(VA[3], VA[3]);
    chk("R5 square a", prod, ref_sq(VA[3]));
    run(VA[1], VA[1]);
    chk("R5 square ones", prod, ref_sq(VA[1]));

    // R6 zero and one
    run('0, VA[4]);
    chk("R6 zero", prod, '0);
    run(M'(1), VA[4]);
    chk("R6 one", prod, VA[4]);

    // R7 fold boundaries
    run({1'b1, {(M-1){1'b0}}}, M'(2));
    chk("R7 single fold", prod, M'(1) | (M'(1) << 74));
    run({1'b1, {(M-1){1'b0}}}, {1'b1, {(M-1){1'b0}}});
    chk("R7 double fold", prod, (M'(1) << 231) | (M'(1) << 146) | (M'(1) << 72));

    // R8 swapped operands
    run(VB[0], VA[0]);
    chk("R8 swap", prod, ref_mul(VA[0], VB[0]));

    // R9 back-to-back strobes
    @(negedge clk);
    opa = VA[2]; opb = VB[2]; go = 1'b1;
    @(negedge clk);
    chk("R9 first", prod, ref_mul(VA[2], VB[2]));
    opa = VA[3]; opb = VB[4];
    @(negedge clk);
    chk("R9 second", prod, ref_mul(VA[3], VB[4]));
    chk("R9 vld kept", M'(prod_vld), M'(1));
    opa = VA[0]; opb = VA[0];
    @(negedge clk);
    go = 1'b0;
    chk("R9 third", prod, ref_sq(VA[0]));

    // R4 asynchronous reset mid-run
    #1.0 rst_n = 1'b0;
    #0.5;
    chk("R4 async prod", prod, '0);
    chk("R4 async vld", M'(prod_vld), M'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule